// File: doc/BRIEF.md
# Ready-Terminated External Bus Controller

This block is a local bus master that carries out single read and write transfers on an external peripheral bus for one internal requester. Each transfer starts with a one-clock address latch phase and continues with an active-low read or write strobe. During a write the block also drives the data bus and raises a data-out enable.

The strobe phase ends in one of two ways, chosen for each transfer by a configuration bit. In fixed mode the strobe lasts for a programmed number of wait states, from 0 to 15. In ready mode the block first waits a short programmed count of 0 to 7 wait states. After that it ends the strobe on the first clock in which the synchronized active-low ready input reads low. The pre-wait lets a peripheral that holds ready low while idle get its ready line high again before the controller looks at it.

The internal side is a level request with direction, address and write data. The request is held until a one-clock acknowledge, and read data comes back alongside that acknowledge. The configuration inputs are captured when a request is accepted.

Top module: `ready_bus_ctrl`

## Requirements
- R1: After reset, bus_ale and bus_dout_en are 0, bus_rd_n and bus_wr_n are 1, and req_ack is 0.
- R2: An accepted request produces exactly one clock of bus_ale. The strobe follows in the next clock: bus_rd_n for req_write=0, bus_wr_n for req_write=1. The two strobes are never low together and neither is low during bus_ale. bus_addr holds req_addr throughout.
- R3: With cfg_ready_en=0, the strobe stays low for exactly cfg_fixed_wait+1 clocks, whatever the level of bus_ready_n.
- R4: With cfg_ready_en=1, the strobe stays low for at least cfg_pre_wait+1 clocks. bus_ready_n passes through a two-flop synchronizer. If bus_ready_n goes low before the posedge ending strobe clock d (counted from 0), the strobe lasts max(d+2, cfg_pre_wait)+1 clocks.
- R5: With cfg_ready_en=1 and bus_ready_n held low throughout, the strobe lasts exactly cfg_pre_wait+1 clocks.
- R6: A peripheral may hold bus_ready_n low while idle and release it only once the strobe starts. Its stale low level then has no effect, provided cfg_pre_wait is at least 2. Ready is not examined outside the strobe phase.
- R7: For reads, bus_din is captured on the last strobe clock and presented on rsp_rdata in the next clock. That clock is the only one in which req_ack is 1, and both strobes are high in it.
- R8: For writes, bus_dout equals req_wdata and bus_dout_en is 1 during the address latch and strobe phases. For reads, bus_dout_en is 0.
- R9: At least one clock with both strobes high and bus_ale low separates the end of a strobe from the next bus_ale.
- R10: The configuration inputs are sampled when a request is accepted. Changing them during a transfer affects only the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request, held until req_ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| req_ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DW | Read data, valid with req_ack |
| cfg_ready_en | input | 1 | 1 = ready-terminated, 0 = fixed length |
| cfg_fixed_wait | input | FW | Wait states in fixed mode |
| cfg_pre_wait | input | PW | Wait states before ready is examined |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | AW | External address |
| bus_dout | output | DW | External write data |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | DW | External read data |
| bus_ready_n | input | 1 | Asynchronous ready, active low |

## Verification
The bound checker watches the bus phases on every clock:
- the strobes are mutually exclusive and never overlap address latch;
- the address latch lasts one clock and is always followed by a strobe;
- the idle clock after each strobe is present;
- the acknowledge is a single pulse that comes straight after a strobe;
- the data-out enable follows the direction.

Only the bench scenarios can show strobe lengths, because those depend on the captured configuration and on when ready arrives. This covers the fixed counts, the synchronizer latency in ready mode, and a normally-ready peripheral that is ignored during the pre-wait. The bench also checks the read data values and that a configuration change in mid-transfer takes effect only on the next transfer.

// File: rtl/ready_bus_ctrl.sv
module ready_bus_ctrl #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int FW = 4,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ack,
  output logic [DW-1:0] rsp_rdata,
  input  logic          cfg_ready_en,
  input  logic [FW-1:0] cfg_fixed_wait,
  input  logic [PW-1:0] cfg_pre_wait,
  output logic          bus_ale,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dout_en,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_ready_n
);
  localparam int CW = (FW > PW) ? FW : PW;

  typedef enum logic [1:0] {ST_IDLE, ST_ALE, ST_STROBE, ST_GAP} state_t;

  state_t          state;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [DW-1:0]   rdata_q;
  logic            wr_q;
  logic            rdy_en_q;
  logic [FW-1:0]   fixed_q;
  logic [PW-1:0]   pre_q;
  logic [CW-1:0]   cnt;
  logic [1:0]      rdy_sync;
  logic            ack_q;
  logic            done;
  logic            in_strobe;

  assign in_strobe = (state == ST_STROBE);
  assign done = rdy_en_q ? ((cnt >= CW'(pre_q)) && !rdy_sync[1])
                         : (cnt == CW'(fixed_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_sync <= 2'b11;
    else        rdy_sync <= {rdy_sync[0], bus_ready_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      wr_q     <= 1'b0;
      rdy_en_q <= 1'b0;
      fixed_q  <= '0;
      pre_q    <= '0;
      cnt      <= '0;
      ack_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      ack_q <= in_strobe && done;
      case (state)
        ST_IDLE: if (req_valid) begin
          state    <= ST_ALE;
          addr_q   <= req_addr;
          wdata_q  <= req_wdata;
          wr_q     <= req_write;
          rdy_en_q <= cfg_ready_en;
          fixed_q  <= cfg_fixed_wait;
          pre_q    <= cfg_pre_wait;
        end
        ST_ALE: begin
          state <= ST_STROBE;
          cnt   <= '0;
        end
        ST_STROBE: begin
          if (done) begin
            state <= ST_GAP;
            if (!wr_q) rdata_q <= bus_din;
          end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bus_ale     = (state == ST_ALE);
  assign bus_rd_n    = !(in_strobe && !wr_q);
  assign bus_wr_n    = !(in_strobe && wr_q);
  assign bus_addr    = addr_q;
  assign bus_dout    = wdata_q;
  assign bus_dout_en = wr_q && (bus_ale || in_strobe);
  assign req_ack     = ack_q;
  assign rsp_rdata   = rdata_q;
endmodule

// File: rtl/ready_bus_ctrl_checker.sv
module ready_bus_ctrl_checker (
  input logic clk,
  input logic rst_n,
  input logic req_ack,
  input logic bus_ale,
  input logic bus_rd_n,
  input logic bus_wr_n,
  input logic bus_dout_en
);
  logic strb;
  assign strb = !bus_rd_n || !bus_wr_n;

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> (!bus_ale && bus_rd_n && bus_wr_n && !req_ack)); // R1
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(!bus_rd_n && !bus_wr_n)); // R2
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) bus_ale |-> !strb); // R2
  AST_ALE_THEN_STROBE: assert property (@(posedge clk) disable iff (!rst_n) bus_ale |=> (!bus_ale && strb)); // R2
  AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $rose(req_ack) |-> ($past(strb) && !strb)); // R7
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) req_ack |=> !req_ack); // R7
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) !bus_wr_n |-> bus_dout_en); // R8
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) !bus_rd_n |-> !bus_dout_en); // R8
  AST_GAP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n) ($rose(bus_rd_n) || $rose(bus_wr_n)) |-> (!bus_ale && !strb)); // R9
endmodule

bind ready_bus_ctrl ready_bus_ctrl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .bus_ale(bus_ale),
  .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_dout_en(bus_dout_en)
);

// File: tb/ready_bus_ctrl_tb_top.sv
module ready_bus_ctrl_tb_top;
  localparam int AW = 16, DW = 16, FW = 4, PW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, bus_din = '0;
  logic cfg_ready_en = 0;
  logic [FW-1:0] cfg_fixed_wait = '0;
  logic [PW-1:0] cfg_pre_wait = '0;
  logic bus_ready_n = 1'b1;
  logic req_ack, bus_ale, bus_rd_n, bus_wr_n, bus_dout_en;
  logic [DW-1:0] rsp_rdata, bus_dout;
  logic [AW-1:0] bus_addr;

  int checks = 0, errors = 0;
  int per_mode = 0, per_d = 0, scnt = 0;
  bit prev_strb = 0, gap_bad = 0, mid_change = 0;

  always #4 clk = ~clk;

  ready_bus_ctrl #(.AW(AW), .DW(DW), .FW(FW), .PW(PW)) dut_i (.*);

  // peripheral model: 0 never ready, 1 always ready, 2 ready d clocks into strobe,
  // 3 ready while idle, busy at strobe start, ready again d clocks in
  always @(negedge clk) begin
    if (!bus_rd_n || !bus_wr_n) begin
      bus_ready_n <= (per_mode == 0) ? 1'b1 : (per_mode == 1) ? 1'b0 : !(scnt >= per_d);
      scnt <= scnt + 1;
    end else begin
      scnt <= 0;
      bus_ready_n <= !(per_mode == 1 || per_mode == 3);
    end
    if (bus_ale && prev_strb) gap_bad = 1;
    prev_strb = !bus_rd_n || !bus_wr_n;
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input int exp_len, input string r);
    int ale_n = 0, len = 0, waited = 0;
    bit seen = 0, dir_ok = 1, addr_ok = 1, dout_ok = 1;
    logic [DW-1:0] got = '0;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    bus_din = wr ? '0 : ~d;
    while (!seen && waited < 200) begin
      @(negedge clk); waited++;
      if (bus_ale) ale_n++;
      if (!bus_rd_n || !bus_wr_n) begin
        len++;
        if (wr ? bus_wr_n : bus_rd_n) dir_ok = 0;
        if (bus_addr !== a) addr_ok = 0;
        if (bus_dout_en !== wr || (wr && bus_dout !== d)) dout_ok = 0;
        if (mid_change && len == 1) cfg_fixed_wait = 4'd9;
      end
      if (req_ack) begin seen = 1; got = rsp_rdata; req_valid = 0; end
    end
    chk(seen, "watchdog", waited, 0);
    chk(len == exp_len, r, len, exp_len);
    chk(ale_n == 1 && dir_ok && addr_ok, "R2", ale_n, 1);
    chk(dout_ok, "R8", dout_ok, 1);
    if (!wr) chk(got === ~d, "R7", got, ~d);
    @(negedge clk);
    chk(!req_ack, "R7 ack width", req_ack, 0);
  endtask

  task automatic t_reset();
    chk(!bus_ale && bus_rd_n && bus_wr_n && !bus_dout_en && !req_ack, "R1", bus_ale, 0);
  endtask

  task automatic t_fixed();
    cfg_ready_en = 0;
    per_mode = 0; cfg_fixed_wait = 0;  xfer(0, 16'h1234, 16'h00ff, 1, "R3 w0");
    cfg_fixed_wait = 15;               xfer(1, 16'h4321, 16'hbeef, 16, "R3 w15");
    per_mode = 1; cfg_fixed_wait = 5;  xfer(0, 16'h0001, 16'h5a5a, 6, "R3 ready ignored");
  endtask

  task automatic t_ready_low();
    cfg_ready_en = 1; per_mode = 1;
    cfg_pre_wait = 0; xfer(0, 16'h0010, 16'h1111, 1, "R5 p0");
    cfg_pre_wait = 7; xfer(1, 16'h0020, 16'h2222, 8, "R5 p7");
  endtask

  task automatic t_ready_late();
    cfg_ready_en = 1; per_mode = 2;
    cfg_pre_wait = 0; per_d = 4; xfer(0, 16'h0030, 16'h3333, 7, "R4 d4 p0");
    cfg_pre_wait = 7; per_d = 1; xfer(1, 16'h0040, 16'h4444, 8, "R4 d1 p7");
    cfg_pre_wait = 3; per_d = 2; xfer(0, 16'h0050, 16'h5555, 5, "R4 d2 p3");
  endtask

  task automatic t_normally_ready();
    cfg_ready_en = 1; per_mode = 3;
    cfg_pre_wait = 2; per_d = 3; xfer(0, 16'h0060, 16'h6666, 6, "R6 d3");
    per_d = 5;                   xfer(1, 16'h0070, 16'h7777, 8, "R6 d5");
  endtask

  task automatic t_cfg_latch();
    cfg_ready_en = 0; per_mode = 1; cfg_fixed_wait = 3;
    mid_change = 1; xfer(0, 16'h0080, 16'h8888, 4, "R10 old value");
    mid_change = 0; xfer(0, 16'h0090, 16'h9999, 10, "R10 new value");
  endtask

  task automatic t_gap();
    gap_bad = 0;
    cfg_ready_en = 0; cfg_fixed_wait = 0;
    xfer(1, 16'h00a0, 16'haaaa, 1, "R9 first");
    xfer(1, 16'h00b0, 16'hbbbb, 1, "R9 second");
    chk(!gap_bad, "R9 idle clock", gap_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_fixed();
    t_ready_low();
    t_ready_late();
    t_normally_ready();
    t_cfg_latch();
    t_gap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule